// File: doc/BRIEF.md
# Bit-Serial Rotate-and-Accumulate Unit

This unit builds a z-bit accumulator out of message blocks that arrive one bit per cycle. It rotates each block left by a circular shift amount and XORs the result into the accumulator. There is no parallel rotator. Instead, a write pointer starts at the shift amount and steps forward modulo z, one step per accepted bit. A one-hot decode of that pointer picks the single accumulator bit that the incoming bit toggles. In a quasi-cyclic parity encoder, a row result is the XOR of several rotated message blocks, and this unit forms that result one block after another.

A block begins with a start strobe while the unit is idle. The strobe carries the shift code and the expansion size z. The next z accepted bits, qualified by a valid input, form the block. A shift code of 97 marks an empty block. Its bits are still counted so that the serial stream stays aligned, but they do not change the accumulator. A one-cycle done pulse follows the last bit of a block. A synchronous clear empties the accumulator before a new row begins. The accumulator is visible at the ports at all times.

The caller must keep z a multiple of 4 in the range 4 to 96. For every block that is not empty, the shift code must be less than z.

Top module: `serial_rot_acc`

## Requirements
- R1: After reset, `acc` is all zero and `busy` and `blk_done` are low.
- R2: A `blk_start` seen while `busy` is low latches `shift_in` and `z_in` and raises `busy` in the next cycle. A `blk_start` seen while `busy` is high is ignored, and the block in progress continues unchanged.
- R3: The i-th accepted bit of a block (counting from 0 in arrival order, where a bit is accepted when `busy` and `bit_vld` are both high) is XORed into `acc[(s+i) mod z]`, where s is the latched shift. This is a left circular rotation by s. Bits at index z and above are never touched by the block.
- R4: The write position wraps from z-1 to 0, modulo the latched z and not modulo 96.
- R5: When the latched shift code equals 97, the block's z bits are still accepted and counted, but `acc` does not change.
- R6: `blk_done` is high for exactly one cycle, in the cycle after the z-th bit of a block is accepted. `busy` falls in that same cycle.
- R7: A cycle with `bit_vld` low during a block neither changes `acc` nor advances the block.
- R8: A high `clr` sets `acc` to zero in the next cycle. It takes priority over a bit written in the same cycle, and it does not affect the block count or position.
- R9: Blocks that follow one another without a clear add into `acc` by XOR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous accumulator clear |
| blk_start | input | 1 | Start-of-block strobe |
| shift_in | input | 7 | Shift code: 0..z-1 is a rotation, 97 is an empty block |
| z_in | input | 7 | Expansion size z of the block |
| bit_vld | input | 1 | Serial bit valid |
| bit_in | input | 1 | Serial data bit |
| busy | output | 1 | A block is in progress |
| blk_done | output | 1 | One-cycle pulse after the last bit of a block |
| acc | output | 96 | Accumulator contents |

## Verification
Random message blocks are sent with every shift value for z = 4, 12 and 96. For every multiple of 4, a block uses the largest legal shift. Together these separate correct modulo-z wrapping from wrapping at 96 or off-by-one pointer starts. Chained blocks without a clear show XOR accumulation and that bits above z are left alone. Empty-code blocks, stalls with a set data bit on the line, a start strobe during a block, and a clear that coincides with a bit write each isolate one of the control rules.

// File: rtl/serial_rot_acc_pkg.sv
// Package: default sizes and the empty-block code for the serial
// rotate-and-accumulate unit.
// Assumes: maximum expansion size 96, shift codes carried in 7 bits.
package serial_rot_acc_pkg;
    localparam int DEF_ZMAX      = 96;
    localparam int DEF_SHW       = 7;
    localparam int DEF_NULL_CODE = 97;
endpackage

// File: rtl/sra_ctrl.sv
// Module: sra_ctrl
// Sequences one block. It latches the shift and size at the start strobe,
// counts accepted bits, and steps a write position modulo the latched size.
// At the last bit it raises a one-cycle done pulse.
// Assumes: shift < z for non-empty blocks, and 1 <= z <= ZMAX.
module sra_ctrl #(
    parameter int ZMAX      = 96,
    parameter int SHW       = 7,
    parameter int NULL_CODE = 97,
    localparam int PW       = $clog2(ZMAX),
    localparam int ZW       = $clog2(ZMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          blk_start,
    input  logic [SHW-1:0] shift_in,
    input  logic [ZW-1:0] z_in,
    input  logic          bit_vld,
    output logic          busy,
    output logic          blk_done,
    output logic          wr_en,
    output logic [PW-1:0] wr_pos
);
    logic [ZW-1:0] z_q;
    logic [ZW-1:0] cnt_q;
    logic [PW-1:0] pos_q;
    logic          empty_q;
    logic          take;
    logic          last;
    logic          pos_end;

    // Decode whether a bit is taken now and whether it closes the block.
    always_comb begin
        take    = busy && bit_vld;
        last    = take && (cnt_q == ZW'(z_q - ZW'(1)));
        pos_end = (ZW'(pos_q) == ZW'(z_q - ZW'(1)));
        wr_en   = take && !empty_q;
        wr_pos  = pos_q;
    end

    // Block state: latch the setup at start, then count and wrap per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            blk_done <= 1'b0;
            z_q      <= '0;
            cnt_q    <= '0;
            pos_q    <= '0;
            empty_q  <= 1'b0;
        end else begin
            blk_done <= last;
            if (!busy && blk_start) begin
                busy    <= 1'b1;
                z_q     <= z_in;
                cnt_q   <= '0;
                empty_q <= (shift_in == SHW'(NULL_CODE));
                pos_q   <= (shift_in == SHW'(NULL_CODE)) ? '0 : PW'(shift_in);
            end else if (take) begin
                cnt_q <= cnt_q + ZW'(1);
                pos_q <= pos_end ? '0 : pos_q + PW'(1);
                if (last) begin
                    busy <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/sra_bank.sv
// Module: sra_bank
// Accumulator register. Each bit toggles by the serial data bit when the
// write position selects it; a clear empties every bit and wins over a write.
// Assumes: wr_pos < ZMAX whenever wr_en is high.
module sra_bank #(
    parameter int ZMAX = 96,
    localparam int PW  = $clog2(ZMAX)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_pos,
    input  logic            bit_in,
    output logic [ZMAX-1:0] acc
);
    for (genvar g = 0; g < ZMAX; g++) begin : g_cell
        logic hit;
        // Select: this cell is the target of the current write.
        always_comb hit = wr_en && (wr_pos == PW'(g));
        // Cell update: clear, else toggle by the incoming bit when selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc[g] <= 1'b0;
            end else if (clr) begin
                acc[g] <= 1'b0;
            end else if (hit) begin
                acc[g] <= acc[g] ^ bit_in;
            end
        end
    end
endmodule

// File: rtl/serial_rot_acc.sv
// Module: serial_rot_acc (top)
// Bit-serial rotate-and-accumulate. A block of z bits arrives serially and is
// XORed into the accumulator as if rotated left by the shift code; code 97
// marks an empty block that is consumed without effect.
// Assumes: z is a multiple of 4 in 4..ZMAX, and shift < z unless empty.
module serial_rot_acc
    import serial_rot_acc_pkg::*;
#(
    parameter int ZMAX      = DEF_ZMAX,
    parameter int SHW       = DEF_SHW,
    parameter int NULL_CODE = DEF_NULL_CODE,
    localparam int PW       = $clog2(ZMAX),
    localparam int ZW       = $clog2(ZMAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            blk_start,
    input  logic [SHW-1:0]  shift_in,
    input  logic [ZW-1:0]   z_in,
    input  logic            bit_vld,
    input  logic            bit_in,
    output logic            busy,
    output logic            blk_done,
    output logic [ZMAX-1:0] acc
);
    logic          wr_en;
    logic [PW-1:0] wr_pos;

    sra_ctrl #(.ZMAX(ZMAX), .SHW(SHW), .NULL_CODE(NULL_CODE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk_start (blk_start),
        .shift_in  (shift_in),
        .z_in      (z_in),
        .bit_vld   (bit_vld),
        .busy      (busy),
        .blk_done  (blk_done),
        .wr_en     (wr_en),
        .wr_pos    (wr_pos)
    );

    sra_bank #(.ZMAX(ZMAX)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .wr_en  (wr_en),
        .wr_pos (wr_pos),
        .bit_in (bit_in),
        .acc    (acc)
    );
endmodule

// File: rtl/serial_rot_acc_chk.sv
// Module: serial_rot_acc_chk
// Port-level protocol checks for serial_rot_acc. It keeps its own count of
// accepted bits and its own copy of the latched size and empty flag.
module serial_rot_acc_chk #(
    parameter int ZMAX      = 96,
    parameter int SHW       = 7,
    parameter int NULL_CODE = 97,
    localparam int ZW       = $clog2(ZMAX + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            blk_start,
    input logic [SHW-1:0]  shift_in,
    input logic [ZW-1:0]   z_in,
    input logic            bit_vld,
    input logic            busy,
    input logic            blk_done,
    input logic [ZMAX-1:0] acc
);
    logic [ZW-1:0] k_q;
    logic [ZW-1:0] zk_q;
    logic          nk_q;

    // Shadow block tracking for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q  <= '0;
            zk_q <= '0;
            nk_q <= 1'b0;
        end else if (!busy && blk_start) begin
            k_q  <= '0;
            zk_q <= z_in;
            nk_q <= (shift_in == SHW'(NULL_CODE));
        end else if (busy && bit_vld) begin
            k_q <= k_q + ZW'(1);
        end
    end

    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && blk_start) |=> busy);
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bit_vld && (k_q == ZW'(zk_q - ZW'(1)))) |=> (blk_done && !busy));
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> !blk_done);
    a_r3_one_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ($countones(acc ^ $past(acc)) <= 1));
    a_r5_empty_block_still: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && nk_q && !clr) |=> $stable(acc));
    a_r7_stall_still: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bit_vld && !clr) |=> $stable(acc));
    a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));
    a_r1_idle_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !clr) |=> $stable(acc));
endmodule

bind serial_rot_acc serial_rot_acc_chk #(.ZMAX(ZMAX), .SHW(SHW), .NULL_CODE(NULL_CODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .blk_start (blk_start),
    .shift_in  (shift_in),
    .z_in      (z_in),
    .bit_vld   (bit_vld),
    .busy      (busy),
    .blk_done  (blk_done),
    .acc       (acc)
);

// File: tb/tb_serial_rot_acc.sv
module tb_serial_rot_acc;
    localparam int ZMAX = 96;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            clr = 1'b0;
    logic            blk_start = 1'b0;
    logic [6:0]      shift_in = '0;
    logic [6:0]      z_in = '0;
    logic            bit_vld = 1'b0;
    logic            bit_in = 1'b0;
    logic            busy;
    logic            blk_done;
    logic [ZMAX-1:0] acc;

    logic [ZMAX-1:0] exp_acc = '0;
    int              n_chk = 0;
    int              n_bad = 0;

    always #2.5 clk = ~clk;

    serial_rot_acc dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .blk_start(blk_start),
        .shift_in(shift_in), .z_in(z_in), .bit_vld(bit_vld), .bit_in(bit_in),
        .busy(busy), .blk_done(blk_done), .acc(acc)
    );

    task automatic chk(input bit ok, input string req, input logic [ZMAX-1:0] got,
                       input logic [ZMAX-1:0] want);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, want);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        exp_acc = '0;
        chk(acc == '0, "R8 clear", acc, '0);
    endtask

    // One block; optional stalls, a stray start strobe, and a clear on bit clr_at.
    task automatic do_block(input int z, input int s, input bit stall,
                            input bit stray, input int clr_at);
        logic [ZMAX-1:0] u;
        bit mid_ok;
        for (int i = 0; i < ZMAX; i++) u[i] = 1'($urandom);
        @(negedge clk);
        blk_start = 1'b1; shift_in = 7'(s); z_in = 7'(z);
        @(negedge clk);
        blk_start = 1'b0;
        mid_ok = 1'b1;
        for (int i = 0; i < z; i++) begin
            if (stall && (i % 3 == 1)) begin
                bit_vld = 1'b0; bit_in = 1'b1;
                @(negedge clk);
            end
            if (stray && i == 2) begin
                blk_start = 1'b1; shift_in = 7'd0; z_in = 7'd4;
            end
            bit_vld = 1'b1; bit_in = u[i];
            clr = (i == clr_at);
            if (i == clr_at) exp_acc = '0;
            else if (s != 97) exp_acc[(s + i) % z] ^= u[i];
            @(negedge clk);
            blk_start = 1'b0; clr = 1'b0;
            if (i < z - 1 && (blk_done || !busy)) mid_ok = 1'b0;
        end
        bit_vld = 1'b0; bit_in = 1'b0;
        chk(mid_ok, "R6 no early done", {95'd0, mid_ok}, {95'd0, 1'b1});
        chk(blk_done && !busy, "R6 done after last bit", {94'd0, blk_done, busy}, 96'd2);
        chk(acc == exp_acc, (s == 97) ? "R5 empty block" : "R3 R4 rotate accumulate", acc, exp_acc);
        @(negedge clk);
        chk(!blk_done, "R6 done one cycle", {95'd0, blk_done}, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc == '0 && !busy && !blk_done, "R1 reset state",
            {busy, blk_done, acc[93:0]}, '0);
        // R2: busy rises after start
        @(negedge clk); blk_start = 1'b1; shift_in = 7'd1; z_in = 7'd4;
        @(negedge clk); blk_start = 1'b0;
        chk(busy, "R2 busy after start", {95'd0, busy}, 96'd1);
        for (int i = 0; i < 4; i++) begin
            bit_vld = 1'b1; bit_in = 1'b0; @(negedge clk);
        end
        bit_vld = 1'b0;
        @(negedge clk);
        // R3 R4: all shifts for small and full sizes
        for (int s = 0; s < 4; s++) do_block(4, s, 0, 0, -1);
        do_clear();
        for (int s = 0; s < 12; s++) do_block(12, s, 0, 0, -1);
        for (int s = 0; s < 96; s++) do_block(96, s, 0, 0, -1);
        // R4 R9: largest shift for every size, chained without a clear
        for (int z = 4; z <= 96; z += 4) do_block(z, z - 1, 0, 0, -1);
        // R5: empty blocks leave the accumulator alone
        do_block(8, 97, 0, 0, -1);
        do_block(96, 97, 1, 0, -1);
        // R7: stalls with a set data bit on the line
        do_block(40, 17, 1, 0, -1);
        // R2: start strobe during a block is ignored
        do_block(20, 5, 0, 1, -1);
        // R8: clear on a write cycle wins
        do_block(16, 9, 0, 0, 6);
        do_clear();
        do_block(24, 23, 1, 1, -1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule